// File: doc/BRIEF.md
# Floating-Point CSR Access Unit

This unit keeps the floating-point control and status state of a scalar core: five sticky exception flags and a three-bit rounding-mode field, eight bits in all. It executes the six Zicsr instructions (register and immediate forms of read-write, read-set and read-clear) when they target one of three views of that state. Address 0x001 is the flags alone, 0x002 is the rounding mode alone and 0x003 is the whole eight-bit word. The integer pipeline presents one instruction word with a valid strobe and the rs1 operand. The unit answers one cycle later with a registered destination index, write data and write enable, or with an illegal-CSR pulse.

The value returned to the destination register is always the view as it stood before the instruction, zero-extended to XLEN. The modification is applied after that read. The set and clear forms skip the CSR write entirely when the source field is zero, and the read still takes place. The FPU ORs new exception flags in through a separate port in every cycle. A CSR write in the same cycle overrides that accumulation.

Top module: `fpcsr_unit`

## Requirements
- R1: Only instr[6:0] = 7'b1110011 with funct3 = instr[14:12] in {001, 010, 011, 101, 110, 111} is executed. Any other valid word gives no rd write, no illegal pulse and no state change.
- R2: One cycle after a legal strobe, rd_wdata holds the pre-instruction view value zero-extended to XLEN. rd_idx holds instr[11:7].
- R3: Address instr[31:20] = 0x001 views state bits [4:0], 0x002 views bits [7:5] and 0x003 views bits [7:0]. All bits above a view's width read as zero.
- R4: The write forms (funct3 001, 101) replace the view with the low bits of the mask, even when the mask is zero.
- R5: The set forms (funct3 010, 110) OR the mask into the view.
- R6: The clear forms (funct3 011, 111) clear each view bit whose mask bit is 1 and leave all other bits unchanged.
- R7: The immediate forms (funct3[2] = 1) use instr[19:15] zero-extended as the mask. The register forms use rs1_value.
- R8: A set or clear form whose instr[19:15] is zero does not write the CSR. rd still receives the old value.
- R9: Any other address raises csr_illegal for one cycle, one cycle after the strobe. rd_we stays low and the state is unchanged.
- R10: With instr[11:7] = 0, rd_we stays low, but the CSR update still happens.
- R11: fpu_flags is ORed into state bits [4:0] in every cycle without a CSR write. In a cycle with a CSR write, the write wins and the flags of that cycle are dropped.
- R12: Back-to-back strobes are accepted every cycle. Each instruction sees the state left by the previous one.
- R13: After reset, the state is zero and rd_we and csr_illegal are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Instruction word |
| rs1_value | input | XLEN | Source register operand |
| fpu_flags | input | 5 | Exception flags to accumulate |
| rd_idx | output | 5 | Destination register index |
| rd_wdata | output | XLEN | Destination write data |
| rd_we | output | 1 | Destination write enable |
| csr_illegal | output | 1 | Access to an unsupported CSR address |

## Verification
Random words mix all eight funct3 codes, the three legal addresses, stray addresses and corrupted opcodes. Sources are zero about a quarter of the time, which separates the suppressed set/clear case from the write forms that must still write. Random flag accumulation runs alongside, so collisions with CSR writes occur, and frequent whole-word reads show whether the alias views stay coherent. Directed cases replay the 0x54 / fflags clear scenario, which tells a read taken before the update from one taken after.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;

  localparam int FLAGS_W = 5;
  localparam int RM_W    = 3;
  localparam int STATE_W = FLAGS_W + RM_W;

  localparam logic [6:0]  OPC_SYSTEM = 7'b1110011;
  localparam logic [11:0] ADDR_FLAGS = 12'h001;
  localparam logic [11:0] ADDR_RM    = 12'h002;
  localparam logic [11:0] ADDR_ALL   = 12'h003;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  typedef enum logic [1:0] {
    VIEW_FLAGS = 2'd0,
    VIEW_RM    = 2'd1,
    VIEW_ALL   = 2'd2,
    VIEW_BAD   = 2'd3
  } csr_view_e;

  typedef struct packed {
    logic       is_csr;
    csr_op_e    op;
    logic       use_imm;
    logic [4:0] src;
    logic [4:0] rd;
    csr_view_e  view;
  } csr_dec_t;

  // Value of a view, right-aligned, with the upper bits zero.
  function automatic logic [STATE_W-1:0] view_read(csr_view_e v, logic [STATE_W-1:0] st);
    logic [STATE_W-1:0] r;
    unique case (v)
      VIEW_FLAGS: r = {{RM_W{1'b0}}, st[FLAGS_W-1:0]};
      VIEW_RM:    r = {{FLAGS_W{1'b0}}, st[STATE_W-1:FLAGS_W]};
      VIEW_ALL:   r = st;
      default:    r = '0;
    endcase
    return r;
  endfunction

  // Place a right-aligned view value back into the full state word.
  function automatic logic [STATE_W-1:0] view_merge(csr_view_e v, logic [STATE_W-1:0] st,
                                                    logic [STATE_W-1:0] val);
    logic [STATE_W-1:0] r;
    unique case (v)
      VIEW_FLAGS: r = {st[STATE_W-1:FLAGS_W], val[FLAGS_W-1:0]};
      VIEW_RM:    r = {val[RM_W-1:0], st[FLAGS_W-1:0]};
      VIEW_ALL:   r = val;
      default:    r = st;
    endcase
    return r;
  endfunction

  // Read-modify arithmetic of the three instruction kinds.
  function automatic logic [STATE_W-1:0] apply_op(csr_op_e op, logic [STATE_W-1:0] old,
                                                  logic [STATE_W-1:0] mask);
    logic [STATE_W-1:0] r;
    unique case (op)
      OP_WRITE: r = mask;
      OP_SET:   r = old | mask;
      OP_CLEAR: r = old & ~mask;
      default:  r = old;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fpcsr_decode.sv
module fpcsr_decode
  import fpcsr_pkg::*;
(
  input  logic [31:0] instr,
  output csr_dec_t    dec
);

  logic [11:0] addr;
  logic [2:0]  f3;

  assign addr = instr[31:20];
  assign f3   = instr[14:12];

  always_comb begin
    dec         = '0;
    dec.src     = instr[19:15];
    dec.rd      = instr[11:7];
    dec.use_imm = f3[2];
    unique case (f3[1:0])
      2'b01:   dec.op = OP_WRITE;
      2'b10:   dec.op = OP_SET;
      2'b11:   dec.op = OP_CLEAR;
      default: dec.op = OP_NONE;
    endcase
    dec.is_csr = (instr[6:0] == OPC_SYSTEM) && (dec.op != OP_NONE);
    if (addr == ADDR_FLAGS)      dec.view = VIEW_FLAGS;
    else if (addr == ADDR_RM)    dec.view = VIEW_RM;
    else if (addr == ADDR_ALL)   dec.view = VIEW_ALL;
    else                         dec.view = VIEW_BAD;
  end

endmodule

// File: rtl/fpcsr_exec.sv
module fpcsr_exec
  import fpcsr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic               instr_valid,
  input  csr_dec_t           dec,
  input  logic [XLEN-1:0]    rs1_value,
  input  logic [STATE_W-1:0] state_q,
  output logic [STATE_W-1:0] view_old,
  output logic [STATE_W-1:0] state_wr,
  output logic               write_fire,
  output logic               rd_fire,
  output logic               illegal_fire
);

  logic [XLEN-1:0]    mask_full;
  logic [STATE_W-1:0] view_new;
  logic               legal;
  logic               src_nonzero;
  logic               unused_mask_hi;

  assign legal       = instr_valid && dec.is_csr && (dec.view != VIEW_BAD);
  assign src_nonzero = (dec.src != 5'd0);

  assign mask_full      = dec.use_imm ? {{(XLEN-5){1'b0}}, dec.src} : rs1_value;
  assign unused_mask_hi = ^mask_full[XLEN-1:STATE_W];

  // old value is taken from the register before any update
  assign view_old = view_read(dec.view, state_q);
  assign view_new = apply_op(dec.op, view_old, mask_full[STATE_W-1:0]);
  assign state_wr = view_merge(dec.view, state_q, view_new);

  assign write_fire   = legal && ((dec.op == OP_WRITE) || src_nonzero);
  assign rd_fire      = legal && (dec.rd != 5'd0);
  assign illegal_fire = instr_valid && dec.is_csr && (dec.view == VIEW_BAD);

endmodule

// File: rtl/fpcsr_state.sv
module fpcsr_state
  import fpcsr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               write_fire,
  input  logic [STATE_W-1:0] state_wr,
  input  logic [FLAGS_W-1:0] fpu_flags,
  output logic [STATE_W-1:0] state_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (write_fire) begin
      state_q <= state_wr;
    end else begin
      state_q[FLAGS_W-1:0] <= state_q[FLAGS_W-1:0] | fpu_flags;
    end
  end

endmodule

// File: rtl/fpcsr_result.sv
module fpcsr_result
  import fpcsr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_fire,
  input  logic               illegal_fire,
  input  logic [4:0]         rd_in,
  input  logic [STATE_W-1:0] view_old,
  output logic [4:0]         rd_idx,
  output logic [XLEN-1:0]    rd_wdata,
  output logic               rd_we,
  output logic               csr_illegal
);

  localparam int PAD_W = XLEN - STATE_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_we       <= 1'b0;
      csr_illegal <= 1'b0;
      rd_idx      <= '0;
      rd_wdata    <= '0;
    end else begin
      rd_we       <= rd_fire;
      csr_illegal <= illegal_fire;
      if (rd_fire) begin
        rd_idx   <= rd_in;
        rd_wdata <= {{PAD_W{1'b0}}, view_old};
      end
    end
  end

endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
  import fpcsr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [31:0]        instr,
  input  logic [XLEN-1:0]    rs1_value,
  input  logic [FLAGS_W-1:0] fpu_flags,
  output logic [4:0]         rd_idx,
  output logic [XLEN-1:0]    rd_wdata,
  output logic               rd_we,
  output logic               csr_illegal
);

  csr_dec_t           dec;
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_wr;
  logic [STATE_W-1:0] view_old;
  logic               csr_write_fire;
  logic               rd_fire;
  logic               illegal_fire;

  fpcsr_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  fpcsr_exec #(.XLEN(XLEN)) u_exec (
    .instr_valid  (instr_valid),
    .dec          (dec),
    .rs1_value    (rs1_value),
    .state_q      (state_q),
    .view_old     (view_old),
    .state_wr     (state_wr),
    .write_fire   (csr_write_fire),
    .rd_fire      (rd_fire),
    .illegal_fire (illegal_fire)
  );

  fpcsr_state u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .write_fire (csr_write_fire),
    .state_wr   (state_wr),
    .fpu_flags  (fpu_flags),
    .state_q    (state_q)
  );

  fpcsr_result #(.XLEN(XLEN)) u_res (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_fire      (rd_fire),
    .illegal_fire (illegal_fire),
    .rd_in        (dec.rd),
    .view_old     (view_old),
    .rd_idx       (rd_idx),
    .rd_wdata     (rd_wdata),
    .rd_we        (rd_we),
    .csr_illegal  (csr_illegal)
  );

endmodule

// File: rtl/fpcsr_unit_checker.sv
module fpcsr_unit_checker #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instr_valid,
  input logic [31:0]     instr,
  input logic [4:0]      fpu_flags,
  input logic            rd_we,
  input logic [XLEN-1:0] rd_wdata,
  input logic            csr_illegal,
  input logic            csr_write_fire,
  input logic [7:0]      state_q
);

  assert_not_csr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr[6:0] != 7'b1110011) |=> (!rd_we && !csr_illegal));

  assert_rd_hi_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> (rd_wdata[XLEN-1:8] == '0));

  assert_rd_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> $past(instr_valid));

  assert_suppress_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr[13] && instr[19:15] == 5'd0) |-> !csr_write_fire);

  assert_illegal_no_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> !rd_we);

  assert_illegal_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> !$past(csr_write_fire));

  assert_x0_no_we_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr[11:7] == 5'd0) |=> !rd_we);

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_write_fire |=> ((state_q & $past(state_q)) == $past(state_q)));

  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_write_fire && fpu_flags == 5'd0) |=> $stable(state_q));

  assert_write_on_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    csr_write_fire |-> instr_valid);

endmodule

bind fpcsr_unit fpcsr_unit_checker #(.XLEN(XLEN)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .instr_valid    (instr_valid),
  .instr          (instr),
  .fpu_flags      (fpu_flags),
  .rd_we          (rd_we),
  .rd_wdata       (rd_wdata),
  .csr_illegal    (csr_illegal),
  .csr_write_fire (csr_write_fire),
  .state_q        (state_q)
);

// File: tb/fpcsr_unit_test.sv
module fpcsr_unit_test;

  localparam int XLEN   = 64;
  localparam int CLK_PD = 10;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            instr_valid;
  logic [31:0]     instr;
  logic [XLEN-1:0] rs1_value;
  logic [4:0]      fpu_flags;
  logic [4:0]      rd_idx;
  logic [XLEN-1:0] rd_wdata;
  logic            rd_we;
  logic            csr_illegal;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  logic [7:0] m_st;

  always #(CLK_PD/2) clk = ~clk;

  fpcsr_unit #(.XLEN(XLEN)) uut (
    .clk (clk), .rst_n (rst_n), .instr_valid (instr_valid), .instr (instr),
    .rs1_value (rs1_value), .fpu_flags (fpu_flags), .rd_idx (rd_idx),
    .rd_wdata (rd_wdata), .rd_we (rd_we), .csr_illegal (csr_illegal)
  );

  function automatic logic [31:0] mk(logic [11:0] a, logic [4:0] fld, logic [2:0] f3,
                                     logic [4:0] rd, bit bad_op);
    return {a, fld, f3, rd, (bad_op ? 7'b0110011 : 7'b1110011)};
  endfunction

  // bench model of the three views
  function automatic logic [7:0] peek(logic [11:0] a, logic [7:0] s);
    if (a == 12'd1) return s & 8'h1f;
    if (a == 12'd2) return {5'b0, s[7:5]};
    if (a == 12'd3) return s;
    return 8'h00;
  endfunction

  function automatic logic [7:0] poke(logic [11:0] a, logic [7:0] s, logic [7:0] v);
    if (a == 12'd1) return (s & 8'he0) | (v & 8'h1f);
    if (a == 12'd2) return (s & 8'h1f) | {v[2:0], 5'b0};
    return v;
  endfunction

  task automatic check(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [11:0] a, logic [4:0] fld, logic [2:0] f3, logic [4:0] rd,
                       logic [XLEN-1:0] rs1, logic [4:0] fl, bit bad_op, string tag);
    bit is_csr, legal, wr;
    logic [7:0] old, mask, nv;
    @(negedge clk);
    instr_valid = 1'b1;
    instr       = mk(a, fld, f3, rd, bad_op);
    rs1_value   = rs1;
    fpu_flags   = fl;
    is_csr = !bad_op && (f3 != 3'b000) && (f3 != 3'b100);
    legal  = is_csr && (a >= 12'd1) && (a <= 12'd3);
    old    = peek(a, m_st);
    mask   = f3[2] ? {3'b0, fld} : rs1[7:0];
    case (f3[1:0])
      2'b01:   nv = mask;
      2'b10:   nv = old | mask;
      default: nv = old & ~mask;
    endcase
    wr = legal && (f3[1:0] == 2'b01 || fld != 5'd0);
    @(posedge clk);
    #1;
    check({tag, " rd_we"}, rd_we, legal && rd != 5'd0);
    check({tag, " illegal"}, csr_illegal, is_csr && !legal);
    if (legal && rd != 5'd0) begin
      check({tag, " rd_wdata"}, rd_wdata, {56'b0, old});
      check({tag, " rd_idx"}, rd_idx, rd);
    end
    m_st = wr ? poke(a, m_st, nv) : (m_st | {3'b0, fl});
  endtask

  task automatic idle();
    @(negedge clk);
    instr_valid = 1'b0;
    fpu_flags   = 5'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; instr_valid = 1'b0; instr = '0; rs1_value = '0; fpu_flags = '0;
    m_st = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    check("R13 rd_we", rd_we, 0);
    check("R13 illegal", csr_illegal, 0);
    @(negedge clk); rst_n = 1'b1;
    issue(12'd3, 5'd0, 3'b010, 5'd1, '0, 5'd0, 0, "R13 state");

    // old-value capture with the 0x54 scenario
    issue(12'd3, 5'd9, 3'b001, 5'd10, 64'hffff_ff54, 5'd0, 0, "R4 write whole");
    issue(12'd3, 5'd0, 3'b010, 5'd10, '0, 5'd0, 0, "R3 read whole");
    issue(12'd1, 5'd0, 3'b010, 5'd10, '0, 5'd0, 0, "R3 read flags");
    issue(12'd1, 5'd4, 3'b111, 5'd10, '0, 5'd0, 0, "R6 clear imm old");
    issue(12'd1, 5'd0, 3'b010, 5'd10, '0, 5'd0, 0, "R6 after clear");
    issue(12'd2, 5'd0, 3'b110, 5'd11, '0, 5'd0, 0, "R3 read rm");
    // zero source suppression vs write forms
    issue(12'd3, 5'd0, 3'b011, 5'd12, 64'hff, 5'd0, 0, "R8 clear x0");
    issue(12'd3, 5'd0, 3'b010, 5'd12, '0, 5'd0, 0, "R8 unchanged");
    issue(12'd2, 5'd0, 3'b101, 5'd12, '0, 5'd0, 0, "R4 writei zero");
    issue(12'd3, 5'd0, 3'b010, 5'd12, '0, 5'd0, 0, "R4 after zero write");
    issue(12'd2, 5'd6, 3'b110, 5'd13, '0, 5'd0, 0, "R5 set rm");
    issue(12'd1, 5'd0, 3'b010, 5'd13, 64'h3, 5'd0, 0, "R7 reg form");
    // rd = x0 still updates
    issue(12'd1, 5'd5, 3'b001, 5'd0, 64'h1f, 5'd0, 0, "R10 x0 dest");
    issue(12'd3, 5'd0, 3'b010, 5'd14, '0, 5'd0, 0, "R10 readback");
    // illegal address and non-CSR opcode
    issue(12'h004, 5'd7, 3'b101, 5'd15, '0, 5'd0, 0, "R9 bad addr");
    issue(12'h300, 5'd7, 3'b001, 5'd15, 64'hff, 5'd0, 0, "R9 bad addr2");
    issue(12'd3, 5'd7, 3'b001, 5'd15, 64'hff, 5'd0, 1, "R1 bad opcode");
    issue(12'd3, 5'd7, 3'b100, 5'd15, 64'hff, 5'd0, 0, "R1 funct3 100");
    issue(12'd3, 5'd0, 3'b010, 5'd15, '0, 5'd0, 0, "R9 R1 readback");
    // accumulation and collision
    idle();
    fpu_flags = 5'b00110;
    @(negedge clk); fpu_flags = 5'd0; m_st = m_st | 8'h06;
    issue(12'd1, 5'd0, 3'b001, 5'd16, '0, 5'b11000, 0, "R11 collide");
    issue(12'd3, 5'd0, 3'b010, 5'd16, '0, 5'b00001, 0, "R11 accumulate");
    issue(12'd3, 5'd0, 3'b010, 5'd16, '0, 5'd0, 0, "R11 readback");

    for (int i = 0; i < 600; i++) begin
      logic [11:0] a;
      logic [4:0] fld, rd, fl;
      logic [2:0] f3;
      string tag;
      f3  = 3'($urandom % 8);
      a   = ($urandom % 8 < 6) ? 12'(1 + $urandom % 3) : 12'($urandom);
      fld = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
      rd  = ($urandom % 8 == 0) ? 5'd0 : 5'($urandom);
      fl  = ($urandom % 4 == 0) ? 5'($urandom) : 5'd0;
      case (f3[1:0])
        2'b01:   tag = "R12 rand R4";
        2'b10:   tag = "R12 rand R5";
        2'b11:   tag = "R12 rand R6";
        default: tag = "R12 rand R1";
      endcase
      issue(a, fld, f3, rd, {$urandom, $urandom}, fl, ($urandom % 16 == 0), tag);
      if (i % 5 == 4) issue(12'd3, 5'd0, 3'b010, 5'd1, '0, 5'd0, 0, "R3 rand readback");
      if (i % 37 == 0) idle();
    end

    idle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule